// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits between a processor port and its cache controller and keeps track of every memory request that has been sent downstream but has not yet completed. It holds two small fully associative tables indexed by cache-line address. One is for read-class requests and one is for write-class requests. For each presented request it answers in the same cycle with one of four outcomes: accepted, aliased, full, or rejected because the access spans a line boundary. An accepted request is forwarded downstream as a cache command in that same cycle.

Completion is reported on two separate channels, one for reads and one for writes. Each channel carries a line address. A completion that matches a pending entry frees that entry and produces a one-cycle hit pulse upstream. A completion that matches nothing sets a sticky protocol-error flag. A watchdog runs while requests are pending and raises a sticky deadlock flag if any entry has been pending for at least the configured threshold.

Top module: `req_tracker`

## Requirements
- R1: Request type codes are 0 load, 1 instruction fetch, 2 store, 3 RMW-read, 4 RMW-write, 5 locked-read and 6 locked-write. Codes 0 and 1 allocate in the read table. Codes 2 to 6 allocate in the write table and are completed only through the write channel.
- R2: When the byte offset within the line plus `req_len` exceeds LINE_BYTES, the status is 3 (span error) and nothing is issued. This check takes priority over every other outcome.
- R3: When a request's line address matches a pending entry in either table, the status is 1 (aliased) and nothing is issued. The write table is consulted first.
- R4: With no alias, the status is 2 (full) and nothing is issued when the outstanding count is at least MAX_OUT or the request's own table has no free slot. Otherwise the status is 0 and the request is accepted.
- R5: `busy_cnt` always equals the number of pending entries in both tables. It rises by one for each acceptance and falls by one for each matched completion.
- R6: `issue_cmd` encodes fetch as 0, load as 1, store as 2, and every locked or RMW type as 3 (atomic). `issue_line` carries the request's line address.
- R7: `req_mode` is 0 user, 1 supervisor, 2 device. `issue_super` is 1 only for supervisor mode, so device accesses go downstream as user accesses.
- R8: A completion whose line matches a pending entry in its own table frees that entry. In the following cycle it pulses `hit_rd` or `hit_wr` for one cycle.
- R9: A completion with no matching entry in its own table sets `proto_err`, which stays set until reset. Table contents and `busy_cnt` are left unchanged.
- R10: Once a request is inserted, the watchdog checks pending ages every DL_THRESH cycles while anything remains pending. `deadlock` becomes set, and stays set, within 2*DL_THRESH+1 cycles of an insertion that is never completed. It is never set while every entry is completed within DL_THRESH-1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_type | input | 3 | Request type code (R1) |
| req_mode | input | 2 | Access mode code (R7) |
| req_addr | input | ADDR_W | Physical byte address |
| req_len | input | OFF_W+1 | Access length in bytes |
| resp_status | output | 2 | 0 accepted, 1 aliased, 2 full, 3 span error |
| issue_valid | output | 1 | Command sent downstream this cycle |
| issue_cmd | output | 2 | Downstream command (R6) |
| issue_line | output | LINE_W | Line address of the command |
| issue_super | output | 1 | Supervisor access |
| rd_done | input | 1 | Read completion strobe |
| rd_done_line | input | LINE_W | Line of the read completion |
| wr_done | input | 1 | Write completion strobe |
| wr_done_line | input | LINE_W | Line of the write completion |
| hit_rd | output | 1 | Read completion accepted (one cycle later) |
| hit_wr | output | 1 | Write completion accepted (one cycle later) |
| busy_cnt | output | CNT_W | Number of pending requests |
| proto_err | output | 1 | Sticky unmatched-completion flag |
| deadlock | output | 1 | Sticky watchdog flag |

## Verification
The assertions assume that `req_type` never carries code 7 while `req_valid` is high. The bench draws types only from 0 to 6 and keeps `req_len` between 1 and LINE_BYTES. The assertions also assume that completions arrive only as single-cycle strobes with a stable line address. The bench drives each strobe for exactly one clock. Unmatched completions are driven on purpose to exercise R9, and no assertion rules them out; only the stickiness of the resulting flag is asserted.

// File: rtl/req_tracker.sv
module req_tracker #(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 16,
  parameter int RD_SLOTS   = 4,
  parameter int WR_SLOTS   = 4,
  parameter int MAX_OUT    = 6,
  parameter int DL_THRESH  = 256,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int LEN_W  = OFF_W + 1,
  localparam int CNT_W  = $clog2(RD_SLOTS + WR_SLOTS + 1),
  localparam int AGE_W  = $clog2(DL_THRESH + 1),
  localparam int RI_W   = (RD_SLOTS > 1) ? $clog2(RD_SLOTS) : 1,
  localparam int WI_W   = (WR_SLOTS > 1) ? $clog2(WR_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_type,
  input  logic [1:0]        req_mode,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic [1:0]        resp_status,
  output logic              issue_valid,
  output logic [1:0]        issue_cmd,
  output logic [LINE_W-1:0] issue_line,
  output logic              issue_super,
  input  logic              rd_done,
  input  logic [LINE_W-1:0] rd_done_line,
  input  logic              wr_done,
  input  logic [LINE_W-1:0] wr_done_line,
  output logic              hit_rd,
  output logic              hit_wr,
  output logic [CNT_W-1:0]  busy_cnt,
  output logic              proto_err,
  output logic              deadlock
);

  logic [RD_SLOTS-1:0] rd_v, rd_hit, rd_fin, rd_old;
  logic [WR_SLOTS-1:0] wr_v, wr_hit, wr_fin, wr_old;
  logic [LINE_W-1:0]   rd_line [RD_SLOTS];
  logic [LINE_W-1:0]   wr_line [WR_SLOTS];
  logic [AGE_W-1:0]    rd_age  [RD_SLOTS];
  logic [AGE_W-1:0]    wr_age  [WR_SLOTS];
  logic [RI_W-1:0]     rd_pick;
  logic [WI_W-1:0]     wr_pick;

  logic [LINE_W-1:0] req_line;
  logic [OFF_W-1:0]  req_off;
  logic              is_wr, span_bad, accept, rd_fire, wr_fire, aged;
  logic [CNT_W-1:0]  cnt_nx;
  logic              wd_on;
  logic [AGE_W-1:0]  wd_cnt;

  assign req_line = req_addr[ADDR_W-1:OFF_W];
  assign req_off  = req_addr[OFF_W-1:0];
  assign is_wr    = req_type >= 3'd2;
  assign span_bad = ({2'b0, req_off} + {1'b0, req_len}) > (LEN_W+1)'(LINE_BYTES);

  always_comb begin
    for (int i = 0; i < RD_SLOTS; i++) begin
      rd_hit[i] = rd_v[i] && rd_line[i] == req_line;
      rd_fin[i] = rd_v[i] && rd_line[i] == rd_done_line;
      rd_old[i] = rd_v[i] && rd_age[i] == AGE_W'(DL_THRESH);
    end
    for (int i = 0; i < WR_SLOTS; i++) begin
      wr_hit[i] = wr_v[i] && wr_line[i] == req_line;
      wr_fin[i] = wr_v[i] && wr_line[i] == wr_done_line;
      wr_old[i] = wr_v[i] && wr_age[i] == AGE_W'(DL_THRESH);
    end
    rd_pick = '0;
    for (int i = RD_SLOTS - 1; i >= 0; i--)
      if (!rd_v[i]) rd_pick = RI_W'(i);
    wr_pick = '0;
    for (int i = WR_SLOTS - 1; i >= 0; i--)
      if (!wr_v[i]) wr_pick = WI_W'(i);
  end

  always_comb begin
    if (span_bad)                                   resp_status = 2'd3;
    else if (|wr_hit)                               resp_status = 2'd1;
    else if (|rd_hit)                               resp_status = 2'd1;
    else if (busy_cnt >= CNT_W'(MAX_OUT) ||
             (is_wr ? &wr_v : &rd_v))               resp_status = 2'd2;
    else                                            resp_status = 2'd0;
  end

  assign accept      = req_valid && resp_status == 2'd0;
  assign issue_valid = accept;
  assign issue_line  = req_line;
  assign issue_super = req_mode == 2'd1;

  always_comb begin
    case (req_type)
      3'd0:    issue_cmd = 2'd1;
      3'd1:    issue_cmd = 2'd0;
      3'd2:    issue_cmd = 2'd2;
      default: issue_cmd = 2'd3;
    endcase
  end

  assign rd_fire = rd_done && |rd_fin;
  assign wr_fire = wr_done && |wr_fin;
  assign aged    = |rd_old || |wr_old;
  assign cnt_nx  = busy_cnt + CNT_W'(accept) - CNT_W'(rd_fire) - CNT_W'(wr_fire);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_v <= '0;
      for (int i = 0; i < RD_SLOTS; i++) begin
        rd_line[i] <= '0;
        rd_age[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < RD_SLOTS; i++) begin
        if (accept && !is_wr && rd_pick == RI_W'(i)) begin
          rd_v[i]    <= 1'b1;
          rd_line[i] <= req_line;
          rd_age[i]  <= '0;
        end else if (rd_done && rd_fin[i]) begin
          rd_v[i] <= 1'b0;
        end else if (rd_v[i] && rd_age[i] != AGE_W'(DL_THRESH)) begin
          rd_age[i] <= rd_age[i] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_v <= '0;
      for (int i = 0; i < WR_SLOTS; i++) begin
        wr_line[i] <= '0;
        wr_age[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < WR_SLOTS; i++) begin
        if (accept && is_wr && wr_pick == WI_W'(i)) begin
          wr_v[i]    <= 1'b1;
          wr_line[i] <= req_line;
          wr_age[i]  <= '0;
        end else if (wr_done && wr_fin[i]) begin
          wr_v[i] <= 1'b0;
        end else if (wr_v[i] && wr_age[i] != AGE_W'(DL_THRESH)) begin
          wr_age[i] <= wr_age[i] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_cnt  <= '0;
      hit_rd    <= 1'b0;
      hit_wr    <= 1'b0;
      proto_err <= 1'b0;
      deadlock  <= 1'b0;
      wd_on     <= 1'b0;
      wd_cnt    <= '0;
    end else begin
      busy_cnt  <= cnt_nx;
      hit_rd    <= rd_fire;
      hit_wr    <= wr_fire;
      proto_err <= proto_err | (rd_done && !rd_fire) | (wr_done && !wr_fire);
      if (!wd_on) begin
        if (accept) begin
          wd_on  <= 1'b1;
          wd_cnt <= AGE_W'(DL_THRESH - 1);
        end
      end else if (wd_cnt == '0) begin
        if (aged) deadlock <= 1'b1;
        wd_on  <= cnt_nx != '0;
        wd_cnt <= AGE_W'(DL_THRESH - 1);
      end else begin
        wd_cnt <= wd_cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/req_tracker_sva.sv
module req_tracker_sva #(
  parameter int RD_SLOTS = 4,
  parameter int WR_SLOTS = 4,
  parameter int MAX_OUT  = 6,
  parameter int CNT_W    = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [2:0]          req_type,
  input logic [1:0]          resp_status,
  input logic                issue_valid,
  input logic                rd_done,
  input logic                wr_done,
  input logic                hit_rd,
  input logic                hit_wr,
  input logic [CNT_W-1:0]    busy_cnt,
  input logic                proto_err,
  input logic                deadlock,
  input logic [RD_SLOTS-1:0] rd_v,
  input logic [WR_SLOTS-1:0] wr_v
);

  AST_TYPE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_type != 3'd7); // R1
  AST_SPAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && resp_status == 2'd3) |-> !issue_valid); // R2
  AST_ALIAS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && resp_status == 2'd1) |-> !issue_valid); // R3
  AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= CNT_W'(MAX_OUT)); // R4
  AST_CNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt == CNT_W'($countones(rd_v) + $countones(wr_v))); // R5
  AST_CNT_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !rd_done && !wr_done) |=> busy_cnt == $past(busy_cnt) + 1'b1); // R5
  AST_HIT_RD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_rd |-> $past(rd_done)); // R8
  AST_HIT_WR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_wr |-> $past(wr_done)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err); // R9
  AST_DL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    deadlock |=> deadlock); // R10

endmodule

bind req_tracker req_tracker_sva #(
  .RD_SLOTS(RD_SLOTS), .WR_SLOTS(WR_SLOTS), .MAX_OUT(MAX_OUT), .CNT_W(CNT_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
  .resp_status(resp_status), .issue_valid(issue_valid), .rd_done(rd_done),
  .wr_done(wr_done), .hit_rd(hit_rd), .hit_wr(hit_wr), .busy_cnt(busy_cnt),
  .proto_err(proto_err), .deadlock(deadlock), .rd_v(rd_v), .wr_v(wr_v)
);

// File: tb/sim_req_tracker.sv
module sim_req_tracker;
  localparam int AW = 10, LB = 16, NR = 2, NW = 2, MX = 3, TH = 16;
  localparam int LW = AW - 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [2:0] req_type = 0;
  logic [1:0] req_mode = 0;
  logic [AW-1:0] req_addr = 0;
  logic [4:0] req_len = 1;
  logic [1:0] resp_status;
  logic issue_valid, issue_super, hit_rd, hit_wr, proto_err, deadlock;
  logic [1:0] issue_cmd;
  logic [LW-1:0] issue_line;
  logic rd_done = 0, wr_done = 0;
  logic [LW-1:0] rd_done_line = 0, wr_done_line = 0;
  logic [2:0] busy_cnt;

  int n_run = 0, n_bad = 0;
  int mrv[NR], mrl[NR], mwv[NW], mwl[NW];

  always #5 clk = ~clk;

  req_tracker #(.ADDR_W(AW), .LINE_BYTES(LB), .RD_SLOTS(NR), .WR_SLOTS(NW),
                .MAX_OUT(MX), .DL_THRESH(TH)) u0 (.*);

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int m_busy();
    int c = 0;
    for (int i = 0; i < NR; i++) c += mrv[i];
    for (int i = 0; i < NW; i++) c += mwv[i];
    return c;
  endfunction

  function automatic int m_status(input int t, input int a, input int l);
    int line = a / LB;
    int rf = 1, wf = 1;
    if ((a % LB) + l > LB) return 3;
    for (int i = 0; i < NW; i++) if (mwv[i] && mwl[i] == line) return 1;
    for (int i = 0; i < NR; i++) if (mrv[i] && mrl[i] == line) return 1;
    for (int i = 0; i < NR; i++) if (!mrv[i]) rf = 0;
    for (int i = 0; i < NW; i++) if (!mwv[i]) wf = 0;
    if (m_busy() >= MX || (t >= 2 ? wf : rf)) return 2;
    return 0;
  endfunction

  function automatic int m_cmd(input int t);
    return t == 0 ? 1 : t == 1 ? 0 : t == 2 ? 2 : 3;
  endfunction

  task automatic clear_model();
    for (int i = 0; i < NR; i++) mrv[i] = 0;
    for (int i = 0; i < NW; i++) mwv[i] = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    clear_model();
  endtask

  task automatic do_req(input int t, input int m, input int a, input int l, input string rq);
    int es;
    bit done_ins = 0;
    es = m_status(t, a, l);
    @(negedge clk);
    req_valid = 1; req_type = 3'(t); req_mode = 2'(m); req_addr = AW'(a); req_len = 5'(l);
    #1;
    chk(resp_status == 2'(es), rq, resp_status, es);
    chk(issue_valid == (es == 0), rq, issue_valid, es == 0);
    if (es == 0) begin
      chk(issue_cmd == 2'(m_cmd(t)), "R6", issue_cmd, m_cmd(t));
      chk(issue_line == LW'(a / LB), "R6", issue_line, a / LB);
      chk(issue_super == (m == 1), "R7", issue_super, m == 1);
    end
    @(posedge clk); #1;
    req_valid = 0;
    if (es == 0) begin
      if (t >= 2) begin
        for (int i = 0; i < NW; i++) if (!mwv[i] && !done_ins) begin mwv[i] = 1; mwl[i] = a / LB; done_ins = 1; end
      end else begin
        for (int i = 0; i < NR; i++) if (!mrv[i] && !done_ins) begin mrv[i] = 1; mrl[i] = a / LB; done_ins = 1; end
      end
    end
    chk(busy_cnt == 3'(m_busy()), "R5", busy_cnt, m_busy());
  endtask

  task automatic do_done(input bit w, input int line, input string rq);
    bit hit = 0;
    bit err0 = proto_err;
    @(negedge clk);
    if (w) begin wr_done = 1; wr_done_line = LW'(line); end
    else   begin rd_done = 1; rd_done_line = LW'(line); end
    @(posedge clk); #1;
    wr_done = 0; rd_done = 0;
    if (w) begin for (int i = 0; i < NW; i++) if (mwv[i] && mwl[i] == line) begin mwv[i] = 0; hit = 1; end end
    else   begin for (int i = 0; i < NR; i++) if (mrv[i] && mrl[i] == line) begin mrv[i] = 0; hit = 1; end end
    chk((w ? hit_wr : hit_rd) == hit, rq, w ? hit_wr : hit_rd, hit);
    chk((w ? hit_rd : hit_wr) == 0, rq, w ? hit_rd : hit_wr, 0);
    chk(proto_err == (err0 | !hit), "R9", proto_err, err0 | !hit);
    chk(busy_cnt == 3'(m_busy()), "R5", busy_cnt, m_busy());
  endtask

  initial begin
    clear_model();
    do_reset();
    #1;
    chk(busy_cnt == 0, "R5 reset", busy_cnt, 0);
    chk(!proto_err && !deadlock && !hit_rd && !hit_wr, "R9 R10 reset", proto_err + deadlock, 0);

    // R1 R6 R7: every type x mode, completed on its own channel
    for (int t = 0; t < 7; t++)
      for (int m = 0; m < 3; m++) begin
        do_req(t, m, (t * 3 + m) * LB, 4, "R1");
        do_done(t >= 2, t * 3 + m, "R8");
      end

    // R2: every offset and length on one line
    for (int o = 0; o < LB; o++)
      for (int l = 1; l <= LB; l++) begin
        do_req(0, 0, 5 * LB + o, l, "R2");
        if (o + l <= LB) do_done(0, 5, "R8");
      end
    chk(deadlock == 0, "R10 fast completions", deadlock, 0);

    // R3: alias against each table for every type
    do_req(0, 0, 7 * LB, 4, "R3");
    do_req(2, 0, 8 * LB, 4, "R3");
    for (int t = 0; t < 7; t++) begin
      do_req(t, 0, 7 * LB + 8, 4, "R3");
      do_req(t, 1, 8 * LB, 2, "R3");
    end

    // R4: global cap and per-table exhaustion
    do_req(0, 0, 9 * LB, 4, "R4");
    do_req(2, 0, 10 * LB, 4, "R4");
    do_req(1, 0, 11 * LB, 4, "R4");
    do_done(1, 8, "R8");
    do_req(2, 0, 10 * LB, 4, "R4");
    do_done(0, 7, "R8");
    do_done(0, 9, "R8");
    do_req(3, 0, 13 * LB, 4, "R4");
    do_req(6, 0, 14 * LB, 4, "R4");
    do_req(0, 0, 15 * LB, 4, "R4");
    do_req(1, 0, 16 * LB, 4, "R4");
    do_done(1, 10, "R8");
    do_done(1, 13, "R8");
    do_done(0, 15, "R8");

    // R9: unmatched completions leave state intact
    do_req(0, 0, 20 * LB, 4, "R9");
    do_done(1, 20, "R9");
    do_req(1, 0, 20 * LB, 4, "R9");
    do_done(0, 30, "R9");
    do_done(0, 20, "R8");

    // R10: watchdog on a request that never completes
    do_reset();
    do_req(0, 0, 3 * LB, 4, "R10");
    repeat (TH - 3) @(posedge clk);
    #1;
    chk(deadlock == 0, "R10 early", deadlock, 0);
    repeat (TH + 6) @(posedge clk);
    #1;
    chk(deadlock == 1, "R10 late", deadlock, 1);
    do_done(0, 3, "R8");
    repeat (3) @(posedge clk);
    #1;
    chk(deadlock == 1, "R10 sticky", deadlock, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule